// File: doc/BRIEF.md
# VBUS Valid Asymmetric Debouncer

This block turns three raw comparator flags that watch the bus supply into clean status signals. One flag is high when the supply is above the upper (valid) threshold, nominally about 4.07 V. One is high while the supply is above the lower (invalid) threshold, nominally about 3.3 V. The third is high when the supply is below the 0.8 V safe-zero level. The gap between the upper and lower thresholds gives hysteresis. A supply level between them leaves the valid status where it is.

All three flags pass through a synchronizer first. The valid status uses very different debounce times in its two directions. It sets after a short qualification window, sized for about 400 µs of 1 µs ticks. It clears only after a long window, sized for about 15 ms. Any break in the qualifying condition restarts the running window from zero. The safe-zero status is synchronized but not debounced. A one-cycle change event marks every debounced edge of the valid status. Thresholds, references and discharge control sit outside this block.

Top module: `vbus_valid_deb`

## Requirements
- R1: While `vbus_valid` is 0, it becomes 1 on the clock edge that takes the ASSERT_TICKS-th `tick_1us` pulse during which the synchronized `cmp_above_rise` has been continuously 1.
- R2: While `vbus_valid` is 1, it becomes 0 on the clock edge that takes the DEASSERT_TICKS-th `tick_1us` pulse during which the synchronized `cmp_above_fall` has been continuously 0.
- R3: Hysteresis. While `vbus_valid` is 0, `cmp_above_fall` has no effect. While it is 1, `cmp_above_rise` has no effect. With `cmp_above_rise`=0 and `cmp_above_fall`=1, `vbus_valid` holds indefinitely.
- R4: Any cycle in which the qualifying condition is false returns that direction's tick count to zero, so a glitch restarts the full debounce window.
- R5: `vbus_chg` is 1 for exactly the one cycle in which `vbus_valid` takes a new value, and is 0 at all other times.
- R6: During and after reset, `vbus_valid` and `vbus_chg` are 0, both tick counts are cleared, and no change event occurs.
- R7: `vsafe_zero` equals `cmp_below_safe` delayed by SYNC_STAGES clock edges, with no debounce.
- R8: The two threshold flags pass through the same SYNC_STAGES-deep synchronizer before they are qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| cmp_above_rise | input | 1 | High when the supply is above the upper (valid) threshold |
| cmp_above_fall | input | 1 | High when the supply is above the lower (invalid) threshold |
| cmp_below_safe | input | 1 | High when the supply is below the safe-zero level |
| vbus_valid | output | 1 | Debounced supply-valid status |
| vsafe_zero | output | 1 | Synchronized safe-zero status |
| vbus_chg | output | 1 | One-cycle event on each debounced change of `vbus_valid` |

## Verification
A count that fails to restart after a glitch shows at the ports as `vbus_valid` moving early. The error appears a fraction of a debounce window after the glitch, which the per-clock comparison against the bench model catches on that same cycle. A count enabled in the wrong direction shows up as an edge of `vbus_valid` that the hysteresis band should have blocked. A wrong synchronizer depth shifts `vsafe_zero` and every debounced edge by whole cycles, so the mismatch appears on the first transition. Directed scenarios pin the restart and hysteresis cases with expected times worked out by hand.

// File: rtl/vbd_pkg.sv
package vbd_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
      logic safe;
   } vbd_cmp_t;

   function automatic int unsigned vbd_cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/vbd_sync.sv
module vbd_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   initial begin
      assert (WIDTH >= 1) else $error("vbd_sync: WIDTH must be at least 1");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[0] <= '0;
                  else        stage_q[0] <= d_in;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[s] <= '0;
                  else        stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign d_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/vbd_timer.sv
module vbd_timer
   import vbd_pkg::*;
#(
   parameter int unsigned LIMIT = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic qual,
   input  logic tick,
   output logic expire
);

   localparam int unsigned CW = vbd_cnt_bits(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;
   logic          at_last;

   initial begin
      assert (LIMIT >= 2) else $error("vbd_timer: LIMIT must be at least 2");
   end

   assign at_last = (cnt_q == LAST);
   assign expire  = en && qual && tick && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!en || !qual)  cnt_q <= '0;
      else if (tick)          cnt_q <= at_last ? '0 : cnt_q + 1'b1;
   end

   // R4
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || !qual) |=> (cnt_q == '0));

   // R4
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && qual && !tick) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/vbus_valid_deb.sv
module vbus_valid_deb
   import vbd_pkg::*;
#(
   parameter int unsigned ASSERT_TICKS   = 400,
   parameter int unsigned DEASSERT_TICKS = 15000,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1us,
   input  logic cmp_above_rise,
   input  logic cmp_above_fall,
   input  logic cmp_below_safe,
   output logic vbus_valid,
   output logic vsafe_zero,
   output logic vbus_chg
);

   localparam int unsigned FW = $bits(vbd_cmp_t);

   vbd_cmp_t raw_cmp, syn_cmp;
   logic     rise_exp, fall_exp;
   logic     valid_q, chg_q;

   initial begin
      assert (DEASSERT_TICKS > ASSERT_TICKS)
         else $error("vbus_valid_deb: deassert window must exceed assert window");
   end

   assign raw_cmp = '{rise: cmp_above_rise, fall: cmp_above_fall, safe: cmp_below_safe};

   vbd_sync #(.WIDTH(FW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_cmp),
      .d_out (syn_cmp)
   );

   vbd_timer #(.LIMIT(ASSERT_TICKS)) u_rise_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (!valid_q),
      .qual   (syn_cmp.rise),
      .tick   (tick_1us),
      .expire (rise_exp)
   );

   vbd_timer #(.LIMIT(DEASSERT_TICKS)) u_fall_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (valid_q),
      .qual   (!syn_cmp.fall),
      .tick   (tick_1us),
      .expire (fall_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         chg_q   <= 1'b0;
      end else begin
         valid_q <= valid_q ^ (rise_exp | fall_exp);
         chg_q   <= rise_exp | fall_exp;
      end
   end

   assign vbus_valid = valid_q;
   assign vbus_chg   = chg_q;
   assign vsafe_zero = syn_cmp.safe;

   // R1
   rise_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vbus_valid) |-> $past(syn_cmp.rise && tick_1us));

   // R2
   fall_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vbus_valid) |-> $past(!syn_cmp.fall && tick_1us));

   // R5
   chg_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vbus_valid != $past(vbus_valid)) |-> vbus_chg);

   // R5
   chg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vbus_chg |=> !vbus_chg);

   // R3
   hold_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!syn_cmp.rise && syn_cmp.fall) |=> $stable(vbus_valid));

endmodule

// File: tb/vbus_valid_deb_tb.sv
module vbus_valid_deb_tb;

   localparam int A    = 6;
   localparam int D    = 10;
   localparam int SYN  = 2;
   localparam int TDIV = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic rise = 1'b0, fall = 1'b0, safe = 1'b0;
   logic vbus_valid, vsafe_zero, vbus_chg;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   vbus_valid_deb #(.ASSERT_TICKS(A), .DEASSERT_TICKS(D), .SYNC_STAGES(SYN)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick_1us       (tick),
      .cmp_above_rise (rise),
      .cmp_above_fall (fall),
      .cmp_below_safe (safe),
      .vbus_valid     (vbus_valid),
      .vsafe_zero     (vsafe_zero),
      .vbus_chg       (vbus_chg)
   );

   // tick generator
   int tdiv = 0;
   always @(negedge clk) begin
      tdiv = (tdiv + 1) % TDIV;
      tick <= (tdiv == 0);
   end

   // behavioural reference model
   bit m_rq[$], m_fq[$], m_sq[$];
   bit m_valid = 0, m_chg = 0;
   int m_up = 0, m_dn = 0;

   initial begin
      for (int i = 0; i < SYN; i++) begin
         m_rq.push_back(0); m_fq.push_back(0); m_sq.push_back(0);
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 0; m_chg = 0; m_up = 0; m_dn = 0;
         for (int i = 0; i < SYN; i++) begin m_rq[i] = 0; m_fq[i] = 0; m_sq[i] = 0; end
      end else begin
         bit r, f;
         r = m_rq[0]; f = m_fq[0];
         m_chg = 0;
         if (!m_valid) begin
            m_dn = 0;
            if (!r) m_up = 0;
            else if (tick) begin
               m_up++;
               if (m_up == A) begin m_valid = 1; m_chg = 1; m_up = 0; end
            end
         end else begin
            m_up = 0;
            if (f) m_dn = 0;
            else if (tick) begin
               m_dn++;
               if (m_dn == D) begin m_valid = 0; m_chg = 1; m_dn = 0; end
            end
         end
         void'(m_rq.pop_front()); m_rq.push_back(rise);
         void'(m_fq.pop_front()); m_fq.push_back(fall);
         void'(m_sq.pop_front()); m_sq.push_back(safe);
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(vbus_valid == m_valid, "R1 R2 R8", "vbus_valid", vbus_valid, m_valid);
         chk(vbus_chg == m_chg, "R5", "vbus_chg", vbus_chg, m_chg);
         chk(vsafe_zero == m_sq[0], "R7", "vsafe_zero", vsafe_zero, m_sq[0]);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cyc(4);
      chk(vbus_valid == 0, "R6", "valid in reset", vbus_valid, 0);
      chk(vbus_chg == 0, "R6", "chg in reset", vbus_chg, 0);
      rst_n = 1'b1;
      cyc(3);
      chk(vbus_valid == 0 && vbus_chg == 0, "R6", "after reset", vbus_valid, 0);

      // R7: safe flag delayed by exactly SYN edges
      safe = 1'b1;
      cyc(SYN - 1);
      chk(vsafe_zero == 0, "R7", "safe early", vsafe_zero, 0);
      cyc(1);
      chk(vsafe_zero == 1, "R7", "safe latency", vsafe_zero, 1);
      safe = 1'b0;

      // R3: falling flag alone never asserts
      fall = 1'b1;
      cyc(200);
      chk(vbus_valid == 0, "R3", "band hold low", vbus_valid, 0);

      // R1: rise qualifies
      rise = 1'b1;
      cyc(SYN + A * TDIV + 4);
      chk(vbus_valid == 1, "R1", "asserted", vbus_valid, 1);

      // R3: dropping rise while above fall keeps valid
      rise = 1'b0;
      cyc(200);
      chk(vbus_valid == 1, "R3", "band hold high", vbus_valid, 1);

      // R4: glitch restarts deassert window
      fall = 1'b0;
      cyc(20);
      fall = 1'b1;
      cyc(2);
      fall = 1'b0;
      cyc(30);
      chk(vbus_valid == 1, "R4", "restart held valid", vbus_valid, 1);
      cyc(20);
      chk(vbus_valid == 0, "R2", "deasserted", vbus_valid, 0);

      // R4: glitch on the assert side
      rise = 1'b1; fall = 1'b1;
      cyc(14);
      rise = 1'b0;
      cyc(1);
      rise = 1'b1;
      cyc(16);
      chk(vbus_valid == 0, "R4", "assert restarted", vbus_valid, 0);
      cyc(20);
      chk(vbus_valid == 1, "R1", "asserted after restart", vbus_valid, 1);

      // random patterns
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if ($urandom_range(0, 39) == 0) rise = ~rise;
         if ($urandom_range(0, 49) == 0) fall = ~fall;
         if ($urandom_range(0, 9) == 0)  safe = ~safe;
      end

      // R6: reset mid-operation clears state
      rise = 1'b1; fall = 1'b1;
      cyc(60);
      rst_n = 1'b0;
      cyc(2);
      chk(vbus_valid == 0 && vbus_chg == 0, "R6", "reset clears", vbus_valid, 0);
      rst_n = 1'b1;
      cyc(60);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule